// File: doc/BRIEF.md
# Min/Max Genome Circuit Evaluator

The block reads a chromosome that describes a feed-forward circuit. The circuit is a single row of `P` two-input elements, and each element takes either the minimum or the maximum of two earlier signals. A host writes the genes one at a time through a load port and then pulses `start`.

The evaluator works in four phases:
- It checks every element against the connectivity rules.
- It runs the element program once for each 32-lane batch of the `2^N` zero-one input vectors. On single bits, minimum is AND and maximum is OR.
- It compares the node chosen by the output gene against the true median of each vector and counts the matches.
- It walks backward from the output node and counts the elements that actually feed the output.

A single `done` pulse marks the results as valid. This makes the block the fitness stage of a search loop. The search itself, meaning mutation and selection, happens outside.

Node numbering works as follows. Nodes `0..N-1` are the primary inputs, and node `N+j` is the result of element `j`.

The controller has seven states:
- **IDLE** waits for `start`.
- **CHECK** validates element `j` (one per cycle), and checks the output gene along with the last element.
- **LOAD** writes the batch's input words into the node file.
- **EVAL** computes element `j` (one per cycle).
- **SCORE** accumulates the matching lanes of the batch.
- **TRACE** walks the elements from last to first, marking the used ones.
- **FIN** writes the result registers.

The transitions are:
- IDLE→CHECK on `start`.
- CHECK→FIN after the last element if any gene is bad; otherwise CHECK→LOAD.
- LOAD→EVAL.
- EVAL→SCORE after the last element.
- SCORE→LOAD when more batches remain; otherwise SCORE→TRACE.
- TRACE→FIN after element 0.
- FIN→IDLE.

Top module: `cgp_eval`

## Requirements
- R1: A write with `gene_we` high stores `gene_val` at gene `gene_idx`. Genes `3j`, `3j+1` and `3j+2` are the first source, the second source and the function of element `j`. Gene `3P` names the output node.
- R2: Function code 0 makes an element the bitwise AND (minimum) of its sources, and code 1 makes it the bitwise OR (maximum). Any other code makes the chromosome invalid.
- R3: A source gene of element `j` is legal if it is below `N`. It is also legal if it names node `N+i` with `i < j` and `j - i <= L_BACK`. The output gene must be below `N+P`. Any other value makes the chromosome invalid.
- R4: An invalid chromosome reports `invalid`=1, `fitness`=0 and `used_cnt`=0.
- R5: Input vector `v` (0 to `2^N-1`) drives primary input `i` with bit `i` of `v`. `fitness` counts the vectors for which the output node equals the majority of the `N` inputs.
- R6: `used_cnt` counts the elements reachable backward from the output node. An output gene that names a primary input gives 0.
- R7: `done` is a one-cycle pulse. For a valid chromosome it rises on the `2P + B(P+2) + 1`-th clock edge after the edge that samples `start`, where `B = max(1, 2^N/32)`. For an invalid chromosome it rises on the `P+1`-th edge. `busy` is high from the cycle after `start` until `done`.
- R8: While `busy` is high, `start` and gene writes are ignored. The results hold their values between `done` pulses.
- R9: A gene write in the same idle cycle as `start` is stored and is used by the run that this `start` begins.
- R10: After reset, `busy`, `done`, `invalid`, `fitness` and `used_cnt` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gene_we | input | 1 | Gene write strobe |
| gene_idx | input | GIW | Index of the gene to write |
| gene_val | input | NW | Gene value |
| start | input | 1 | Begin an evaluation |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle pulse when results are valid |
| invalid | output | 1 | Chromosome broke a rule |
| fitness | output | N_IN+1 | Count of vectors with the correct median |
| used_cnt | output | UW | Elements feeding the output |

## Verification
Two things can land on the same cycle: a gene write and the `start` that should consume it.

The bench loads a chromosome whose output gene names a primary input. In the same idle cycle as `start`, it rewrites that output gene so it points at the median node. A full score of 8 shows the new gene was used; a score of 6 would show the old one was used.

The bench also tests the converse while the block is busy. It pulses `start` and rewrites the output gene during a run. Both must be ignored: the run ends at the normal latency, and a second run with no further writes must still give the full score.

// File: rtl/cgp_pkg.sv
package cgp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_LOAD,
        ST_EVAL,
        ST_SCORE,
        ST_TRACE,
        ST_FIN
    } cgp_state_e;

    localparam int FN_AND = 0;
    localparam int FN_OR  = 1;

endpackage

// File: rtl/gene_store.sv
module gene_store #(
    parameter int P      = 6,
    parameter int NW     = 4,
    parameter int GIW    = 5,
    parameter int EW     = 3,
    localparam int GENES = 3 * P + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [GIW-1:0] widx,
    input  logic [NW-1:0]  wval,
    input  logic [EW-1:0]  el,
    output logic [NW-1:0]  src_a,
    output logic [NW-1:0]  src_b,
    output logic [NW-1:0]  func,
    output logic [NW-1:0]  out_node
);

    logic [NW-1:0] genes [GENES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < GENES; g++) begin
                genes[g] <= '0;
            end
        end else if (we && int'(widx) < GENES) begin
            genes[int'(widx)] <= wval;
        end
    end

    always_comb begin
        int base;
        base  = 3 * int'(el);
        src_a = '0;
        src_b = '0;
        func  = '0;
        if (base + 2 < GENES) begin
            src_a = genes[base];
            src_b = genes[base + 1];
            func  = genes[base + 2];
        end
        out_node = genes[GENES - 1];
    end

endmodule

// File: rtl/node_bank.sv
module node_bank #(
    parameter int N_IN   = 3,
    parameter int P      = 6,
    parameter int W      = 32,
    parameter int NW     = 4,
    localparam int NODES = N_IN + P
) (
    input  logic                      clk,
    input  logic                      ld_en,
    input  logic [N_IN-1:0][W-1:0]    ld_words,
    input  logic                      wr_en,
    input  logic [NW-1:0]             wr_node,
    input  logic [W-1:0]              wr_data,
    input  logic [NW-1:0]             ra,
    input  logic [NW-1:0]             rb,
    output logic [W-1:0]              da,
    output logic [W-1:0]              db
);

    logic [W-1:0] regs [NODES];

    always_ff @(posedge clk) begin
        if (ld_en) begin
            for (int i = 0; i < N_IN; i++) begin
                regs[i] <= ld_words[i];
            end
        end
        if (wr_en && int'(wr_node) < NODES) begin
            regs[int'(wr_node)] <= wr_data;
        end
    end

    always_comb begin
        da = '0;
        db = '0;
        if (int'(ra) < NODES) da = regs[int'(ra)];
        if (int'(rb) < NODES) db = regs[int'(rb)];
    end

endmodule

// File: rtl/batch_ref.sv
module batch_ref #(
    parameter int N_IN  = 3,
    parameter int W     = 32,
    parameter int BW    = 1,
    localparam int VEC  = 1 << N_IN
) (
    input  logic [BW-1:0]          batch,
    output logic [N_IN-1:0][W-1:0] in_words,
    output logic [W-1:0]           med_word,
    output logic [W-1:0]           lane_mask
);

    always_comb begin
        for (int l = 0; l < W; l++) begin
            int v;
            int ones;
            v    = int'(batch) * W + l;
            ones = 0;
            for (int i = 0; i < N_IN; i++) begin
                in_words[i][l] = (v < VEC) && (((v >> i) & 1) != 0);
                if (((v >> i) & 1) != 0) ones++;
            end
            lane_mask[l] = (v < VEC);
            med_word[l]  = (v < VEC) && (ones > N_IN / 2);
        end
    end

endmodule

// File: rtl/cgp_eval.sv
module cgp_eval
    import cgp_pkg::*;
#(
    parameter int N_IN     = 3,
    parameter int P        = 6,
    parameter int L_BACK   = 6,
    parameter int W        = 32,
    localparam int NODES   = N_IN + P,
    localparam int GENES   = 3 * P + 1,
    localparam int NW      = $clog2(NODES + 1),
    localparam int GIW     = $clog2(GENES),
    localparam int EW      = $clog2(P + 1),
    localparam int FW      = N_IN + 1,
    localparam int UW      = $clog2(P + 1),
    localparam int VEC     = 1 << N_IN,
    localparam int BATCHES = (VEC > W) ? (VEC / W) : 1,
    localparam int BW      = (BATCHES > 1) ? $clog2(BATCHES) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           gene_we,
    input  logic [GIW-1:0] gene_idx,
    input  logic [NW-1:0]  gene_val,
    input  logic           start,
    output logic           busy,
    output logic           done,
    output logic           invalid,
    output logic [FW-1:0]  fitness,
    output logic [UW-1:0]  used_cnt
);

    cgp_state_e state, state_nx;

    logic [EW-1:0]    el;
    logic [BW-1:0]    batch;
    logic             bad;
    logic [FW-1:0]    fit_acc;
    logic [UW-1:0]    use_acc;
    logic [NODES-1:0] used_mask;

    logic [NW-1:0] src_a, src_b, func, out_node;
    logic [N_IN-1:0][W-1:0] in_words;
    logic [W-1:0] med_word, lane_mask, da, db, elem_res, match;
    logic [NW-1:0] rd_a;
    logic cur_bad, last_el;

    function automatic logic src_ok(input logic [NW-1:0] g, input logic [EW-1:0] col);
        int gi;
        int ci;
        gi = int'(g);
        ci = int'(col);
        if (gi < N_IN) return 1'b1;
        return (gi < N_IN + ci) && (N_IN + ci - gi <= L_BACK);
    endfunction

    gene_store #(.P(P), .NW(NW), .GIW(GIW), .EW(EW)) u_genes (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (gene_we && !busy),
        .widx     (gene_idx),
        .wval     (gene_val),
        .el       (el),
        .src_a    (src_a),
        .src_b    (src_b),
        .func     (func),
        .out_node (out_node)
    );

    batch_ref #(.N_IN(N_IN), .W(W), .BW(BW)) u_ref (
        .batch     (batch),
        .in_words  (in_words),
        .med_word  (med_word),
        .lane_mask (lane_mask)
    );

    assign rd_a = (state == ST_SCORE) ? out_node : src_a;

    node_bank #(.N_IN(N_IN), .P(P), .W(W), .NW(NW)) u_nodes (
        .clk      (clk),
        .ld_en    (state == ST_LOAD),
        .ld_words (in_words),
        .wr_en    (state == ST_EVAL),
        .wr_node  (NW'(N_IN + int'(el))),
        .wr_data  (elem_res),
        .ra       (rd_a),
        .rb       (src_b),
        .da       (da),
        .db       (db)
    );

    assign elem_res = (int'(func) == FN_OR) ? (da | db) : (da & db);
    assign match    = ~(da ^ med_word) & lane_mask;
    assign last_el  = (el == EW'(P - 1));
    assign cur_bad  = !src_ok(src_a, el) || !src_ok(src_b, el) || (int'(func) > FN_OR)
                      || (last_el && int'(out_node) >= NODES);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_CHECK;
            ST_CHECK: if (last_el) state_nx = (bad || cur_bad) ? ST_FIN : ST_LOAD;
            ST_LOAD:  state_nx = ST_EVAL;
            ST_EVAL:  if (last_el) state_nx = ST_SCORE;
            ST_SCORE: state_nx = (int'(batch) == BATCHES - 1) ? ST_TRACE : ST_LOAD;
            ST_TRACE: if (el == '0) state_nx = ST_FIN;
            ST_FIN:   state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // datapath counters and accumulators
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            el        <= '0;
            batch     <= '0;
            bad       <= 1'b0;
            fit_acc   <= '0;
            use_acc   <= '0;
            used_mask <= '0;
            fitness   <= '0;
            used_cnt  <= '0;
            invalid   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        el      <= '0;
                        batch   <= '0;
                        bad     <= 1'b0;
                        fit_acc <= '0;
                        use_acc <= '0;
                    end
                end
                ST_CHECK: begin
                    bad <= bad || cur_bad;
                    el  <= last_el ? '0 : el + 1'b1;
                    if (last_el) begin
                        for (int n = 0; n < NODES; n++) begin
                            used_mask[n] <= (n == int'(out_node));
                        end
                    end
                end
                ST_LOAD: begin
                end
                ST_EVAL: begin
                    el <= last_el ? '0 : el + 1'b1;
                end
                ST_SCORE: begin
                    fit_acc <= fit_acc + FW'($countones(match));
                    if (int'(batch) == BATCHES - 1) el <= EW'(P - 1);
                    else                            batch <= batch + 1'b1;
                end
                ST_TRACE: begin
                    if (used_mask[N_IN + int'(el)]) begin
                        use_acc <= use_acc + 1'b1;
                        if (int'(src_a) < NODES) used_mask[int'(src_a)] <= 1'b1;
                        if (int'(src_b) < NODES) used_mask[int'(src_b)] <= 1'b1;
                    end
                    if (el != '0) el <= el - 1'b1;
                end
                ST_FIN: begin
                    invalid  <= bad;
                    fitness  <= bad ? '0 : fit_acc;
                    used_cnt <= bad ? '0 : use_acc;
                end
                default: begin
                end
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= (state == ST_FIN);
    end

    assign busy = (state != ST_IDLE);

endmodule

// File: rtl/cgp_eval_chk.sv
module cgp_eval_chk #(
    parameter int N_IN = 3,
    parameter int P    = 6,
    parameter int FW   = 4,
    parameter int UW   = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          invalid,
    input logic [FW-1:0] fitness,
    input logic [UW-1:0] used_cnt
);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)); // R7

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R7

    AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        invalid |-> (fitness == '0 && used_cnt == '0)); // R4

    AST_FIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fitness) <= (1 << N_IN)); // R5

    AST_USED_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(used_cnt) <= P); // R6

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(fitness) && $stable(used_cnt) && $stable(invalid))); // R8

endmodule

bind cgp_eval cgp_eval_chk #(.N_IN(N_IN), .P(P), .FW(FW), .UW(UW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .invalid  (invalid),
    .fitness  (fitness),
    .used_cnt (used_cnt)
);

// File: tb/sim_cgp_eval.sv
module sim_cgp_eval;

    localparam int N_IN  = 3;
    localparam int P     = 6;
    localparam int LB    = 4;
    localparam int GENES = 3 * P + 1;
    localparam int NCASE = 11;
    localparam int LAT_OK  = 2 * P + (P + 2) + 1;
    localparam int LAT_BAD = P + 1;

    // chromosome table: genes, expected fitness, invalid, used count
    localparam int CH [NCASE][GENES] = '{
        '{1,2,1, 2,2,0, 1,2,0, 0,5,1, 3,6,0, 0,7,1, 7},
        '{1,2,1, 2,2,0, 1,2,0, 0,5,1, 3,6,0, 0,7,1, 0},
        '{1,2,1, 2,2,0, 1,2,0, 0,5,1, 3,6,0, 0,7,1, 3},
        '{1,2,1, 2,2,0, 1,2,0, 0,5,1, 3,6,0, 0,7,1, 4},
        '{1,2,1, 2,2,0, 1,2,0, 0,5,1, 3,6,0, 0,7,1, 8},
        '{5,2,1, 2,2,0, 1,2,0, 0,5,1, 3,6,0, 0,7,1, 7},
        '{1,2,1, 2,2,2, 1,2,0, 0,5,1, 3,6,0, 0,7,1, 7},
        '{1,2,1, 2,2,0, 1,2,0, 0,5,1, 3,6,0, 0,7,1, 9},
        '{1,2,1, 2,2,0, 1,2,0, 0,5,1, 3,6,0, 3,7,1, 7},
        '{3,2,1, 2,2,0, 1,2,0, 0,5,1, 3,6,0, 0,7,1, 7},
        '{0,1,0, 3,2,0, 0,0,0, 0,0,0, 0,0,0, 0,0,0, 4}
    };
    localparam int EXP_FIT  [NCASE] = '{8, 6, 6, 6, 7, 0, 0, 0, 0, 0, 5};
    localparam int EXP_INV  [NCASE] = '{0, 0, 0, 0, 0, 1, 1, 1, 1, 1, 0};
    localparam int EXP_USED [NCASE] = '{4, 0, 1, 1, 5, 0, 0, 0, 0, 0, 2};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gene_we = 1'b0;
    logic [4:0] gene_idx = '0;
    logic [3:0] gene_val = '0;
    logic       start = 1'b0;
    logic       busy, done, invalid;
    logic [3:0] fitness;
    logic [2:0] used_cnt;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    cgp_eval #(.N_IN(N_IN), .P(P), .L_BACK(LB)) u0 (
        .clk(clk), .rst_n(rst_n), .gene_we(gene_we), .gene_idx(gene_idx),
        .gene_val(gene_val), .start(start), .busy(busy), .done(done),
        .invalid(invalid), .fitness(fitness), .used_cnt(used_cnt)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_gene(input int idx, input int val);
        gene_we  = 1'b1;
        gene_idx = 5'(idx);
        gene_val = 4'(val);
        @(posedge clk);
        @(negedge clk);
        gene_we  = 1'b0;
    endtask

    task automatic load_case(input int c);
        for (int g = 0; g < GENES; g++) wr_gene(g, CH[c][g]);
    endtask

    // start, optional same-cycle gene write, optional disturbance mid-run
    task automatic run(output int lat, input int sw_idx, input int sw_val, input bit disturb);
        start = 1'b1;
        if (sw_idx >= 0) begin
            gene_we  = 1'b1;
            gene_idx = 5'(sw_idx);
            gene_val = 4'(sw_val);
        end
        @(posedge clk);
        @(negedge clk);
        start   = 1'b0;
        gene_we = 1'b0;
        chk("R7 busy after start", int'(busy), 1);
        lat = 1;
        if (disturb) begin
            start    = 1'b1;
            gene_we  = 1'b1;
            gene_idx = 5'(GENES - 1);
            gene_val = 4'd0;
        end
        while (!done && lat < 500) begin
            @(posedge clk);
            @(negedge clk);
            start   = 1'b0;
            gene_we = 1'b0;
            if (!done) lat++;
        end
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int lat;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset values
        chk("R10 busy", int'(busy), 0);
        chk("R10 done", int'(done), 0);
        chk("R10 invalid", int'(invalid), 0);
        chk("R10 fitness", int'(fitness), 0);
        chk("R10 used", int'(used_cnt), 0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);

        // table walk: R1 R2 R3 R4 R5 R6 R7
        for (int c = 0; c < NCASE; c++) begin
            load_case(c);
            run(lat, -1, 0, 1'b0);
            chk($sformatf("R5 fitness case %0d", c), int'(fitness), EXP_FIT[c]);
            chk($sformatf("R4 R3 R2 invalid case %0d", c), int'(invalid), EXP_INV[c]);
            chk($sformatf("R6 used case %0d", c), int'(used_cnt), EXP_USED[c]);
            chk($sformatf("R7 latency case %0d", c), lat,
                EXP_INV[c] != 0 ? LAT_BAD : LAT_OK);
            @(negedge clk);
            chk($sformatf("R7 done pulse case %0d", c), int'(done), 0);
            chk($sformatf("R8 hold case %0d", c), int'(fitness), EXP_FIT[c]);
        end

        // R9: output gene names input 0, rewritten to node 7 with start
        load_case(1);
        run(lat, GENES - 1, 7, 1'b0);
        chk("R9 same-cycle write used", int'(fitness), 8);
        chk("R9 used count", int'(used_cnt), 4);

        // R8: start and gene write during busy are ignored
        run(lat, -1, 0, 1'b1);
        chk("R8 latency unaffected", lat, LAT_OK);
        chk("R8 fitness during-busy run", int'(fitness), 8);
        @(negedge clk);
        run(lat, -1, 0, 1'b0);
        chk("R8 busy write ignored", int'(fitness), 8);
        chk("R1 output gene kept", int'(used_cnt), 4);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule